// File: doc/BRIEF.md
# PLL Divider Coefficient Search Engine

This block picks the three divider settings of a clock synthesiser: an input divider M, a feedback multiplier N and a post-divider index PL. It takes a requested output frequency and the reference frequency, both as whole MHz. It then searches for the setting whose output lands closest to the request. Throughout the search it keeps the oscillator (VCO) frequency and the phase-comparison frequency (reference divided by M) inside their legal windows.

A controller presents the two frequencies and pulses `start`. The engine raises `busy` and walks the candidate space one step at a time. Every quotient it needs comes from one shared restoring divider that resolves one bit per clock. When the search ends, the engine loads its result registers and pulses `done` for one cycle. It returns M, N, PL, the remaining error, an exact-match flag, a no-solution flag and the output frequency the chosen setting gives. The result registers hold their values until the next search completes.

Top module: `pll_coef_search`

## Requirements
- R1: PL index i selects a divide ratio. Indices 0 to 14 select, in index order: 1, 2, 3, 4, 5, 6, 8, 10, 12, 16, 12, 16, 20, 24, 32. `pl_o` reports the index, not the ratio.
- R2: A returned solution with `none_o` low satisfies all of the following: M is between 1 and 255; N is between 8 and 255; ref/M (floored) is between 12 and 38; floor(ref*N/M) is between 1000 and the VCO ceiling.
- R3: The internal target T is twice `tgt_mhz`. The padded target is P = T + floor(T/50). The VCO ceiling is 2064, or P when P is larger.
- R4: The PL window is set from two bounds, each clamped to 1..32. The upper bound is ceil(ceiling/P). The lower bound is floor(1000/P). Each bound becomes the lowest index whose ratio is at least the bound.
- R5: PL runs upward through the window. Within each PL, M rises from 1. The M loop ends when ref/M drops below 12 or when floor(T*ratio*M/ref) exceeds 255, and it skips any M whose ref/M is above 38. N takes the floor and then the ceiling of T*ratio*M/ref. Only a strictly smaller error replaces the kept result, and an error of zero ends the search.
- R6: The error of a candidate is |round(vco/ratio) - T|. Rounding adds half the ratio (floored) before dividing. `err_o` returns the error of the kept result, and `exact_o` is high when that error is zero.
- R7: When no candidate qualifies, the result is M=255, N=8, PL=1, `none_o`=1, `exact_o`=0, and `err_o` is all ones.
- R8: `fout_o` equals floor(floor(ref*N/(M*ratio))/2) for the returned M, N and PL.
- R9: `busy` is high from the cycle after an accepted `start` until `done`. `done` is a single-cycle pulse with `busy` low. A `start` during a search is ignored. The results change only when `done` rises.
- R10: While reset is held, `busy` and `done` are low and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a search (taken when idle) |
| tgt_mhz | input | TGT_W | Requested output frequency, MHz |
| ref_mhz | input | REF_W | Reference frequency, MHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| m_o | output | 8 | Chosen input divider |
| n_o | output | 8 | Chosen feedback multiplier |
| pl_o | output | 4 | Chosen post-divider index |
| err_o | output | TGT_W+2 | Error of the result against T |
| exact_o | output | 1 | Result error is zero |
| none_o | output | 1 | No legal candidate existed |
| fout_o | output | TGT_W+1 | Achieved output frequency, MHz |

## Verification
The bench builds the block with its defaults, TGT_W=11 and REF_W=8. With these widths a request can exceed half the fixed VCO ceiling, so the path that raises the ceiling to the padded target can be reached. A reference below 12 MHz can also be applied, and with it no divider passes the comparison-frequency test. The chosen references (12, 26, 27 and 38 MHz) make several M values legal within one PL. These cases exercise the strict-improvement rule and the early exit on an exact match. A set of common core-clock targets is compared against a behavioural model of the search order.

// File: rtl/pll_srch_pkg.sv
// Shared constants, state type and post-divider ratio lookup for the
// PLL coefficient search engine. Assumes ratios never exceed 32.
package pll_srch_pkg;

    localparam int VCO_MIN = 1000;
    localparam int VCO_MAX = 2064;
    localparam int U_MIN   = 12;
    localparam int U_MAX   = 38;
    localparam int M_MAX   = 255;
    localparam int N_MIN   = 8;
    localparam int N_MAX   = 255;
    localparam int PL_NUM  = 15;
    localparam int PAD_DIV = 50;
    localparam int DEF_PL  = 1;
    localparam int BND_MAX = 32;

    typedef enum logic [3:0] {
        S_IDLE, S_PAD, S_HIB, S_LOB, S_PLINIT, S_PLSET, S_UCHK, S_NDIV,
        S_NCHK, S_VCO, S_RND, S_NEXTM, S_NEXTPL, S_FIN, S_FOUT, S_DONE
    } srch_st_t;

    // Divide ratio selected by a post-divider index (non-monotonic).
    function automatic logic [5:0] pl_ratio(input logic [3:0] idx);
        case (idx)
            4'd0:    pl_ratio = 6'd1;
            4'd1:    pl_ratio = 6'd2;
            4'd2:    pl_ratio = 6'd3;
            4'd3:    pl_ratio = 6'd4;
            4'd4:    pl_ratio = 6'd5;
            4'd5:    pl_ratio = 6'd6;
            4'd6:    pl_ratio = 6'd8;
            4'd7:    pl_ratio = 6'd10;
            4'd8:    pl_ratio = 6'd12;
            4'd9:    pl_ratio = 6'd16;
            4'd10:   pl_ratio = 6'd12;
            4'd11:   pl_ratio = 6'd16;
            4'd12:   pl_ratio = 6'd20;
            4'd13:   pl_ratio = 6'd24;
            default: pl_ratio = 6'd32;
        endcase
    endfunction

endpackage

// File: rtl/pll_srch_div.sv
// Restoring shift-subtract divider, one quotient bit per clock.
// Assumes: go is pulsed only while idle; q and r are valid from the
// done pulse until the next go. Division by zero yields all-ones.
module pll_srch_div #(
    parameter int W = 26
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         done,
    output logic [W-1:0] q,
    output logic [W-1:0] r
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  quo, rem, dsr;
    logic [CW-1:0] cnt;
    logic          run;
    logic [W:0]    trial;

    // Partial remainder with the next dividend bit shifted in.
    always_comb trial = {rem, quo[W-1]};

    // Iterate one bit per cycle and flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run  <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
            quo  <= '0;
            rem  <= '0;
            dsr  <= '0;
        end else begin
            done <= 1'b0;
            if (go) begin
                quo <= a;
                rem <= '0;
                dsr <= b;
                cnt <= CW'(W);
                run <= 1'b1;
            end else if (run) begin
                if (trial >= {1'b0, dsr}) begin
                    rem <= W'(trial - {1'b0, dsr});
                    quo <= {quo[W-2:0], 1'b1};
                end else begin
                    rem <= trial[W-1:0];
                    quo <= {quo[W-2:0], 1'b0};
                end
                cnt <= cnt - CW'(1);
                if (cnt == CW'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign q = quo;
    assign r = rem;
endmodule

// File: rtl/pll_srch_plidx.sv
// Maps a divide-ratio bound (1..32) to the lowest post-divider index
// whose ratio reaches it. Assumes the last index holds the largest ratio.
module pll_srch_plidx
    import pll_srch_pkg::*;
(
    input  logic [5:0] bound,
    output logic [3:0] idx
);
    // Scan downward so the lowest qualifying index wins.
    always_comb begin
        idx = 4'(PL_NUM - 1);
        for (int i = PL_NUM - 1; i >= 0; i--) begin
            if (pl_ratio(4'(i)) >= bound) idx = 4'(i);
        end
    end
endmodule

// File: rtl/pll_coef_search.sv
// Sequential search for PLL M/N/PL closest to a target output frequency.
// Assumes tgt_mhz >= 1 and that start is a pulse; all quotients come from
// one shared iterative divider, results are held until the next done.
module pll_coef_search
    import pll_srch_pkg::*;
#(
    parameter int TGT_W = 11,
    parameter int REF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TGT_W-1:0] tgt_mhz,
    input  logic [REF_W-1:0] ref_mhz,
    output logic             busy,
    output logic             done,
    output logic [7:0]       m_o,
    output logic [7:0]       n_o,
    output logic [3:0]       pl_o,
    output logic [TGT_W+1:0] err_o,
    output logic             exact_o,
    output logic             none_o,
    output logic [TGT_W:0]   fout_o
);
    localparam int TT_W  = TGT_W + 1;
    localparam int DW_A  = TT_W + 14;
    localparam int DW_B  = REF_W + 9;
    localparam int DIV_W = (DW_A > DW_B) ? DW_A : DW_B;
    localparam int ERR_W = TGT_W + 2;
    localparam int FO_W  = TGT_W + 1;

    srch_st_t         st;
    logic [TT_W-1:0]  tt;
    logic [REF_W-1:0] ref_q;
    logic [DIV_W-1:0] pad, maxv, best;
    logic [5:0]       hi_bd, lo_bd;
    logic [3:0]       pl, hi_idx, lo_idx, bp;
    logic [7:0]       m, bm, bn;
    logic [8:0]       n, n1;
    logic             found;

    logic             dv_go, dv_done;
    logic [DIV_W-1:0] dv_a, dv_b, dv_q, dv_r;

    logic [DIV_W-1:0] tt_x, ref_x, pad_nx, maxv_nx, rat_x, tv_c, dlt, brat_x;
    logic [5:0]       rat;

    pll_srch_div #(.W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .go(dv_go), .a(dv_a), .b(dv_b),
        .done(dv_done), .q(dv_q), .r(dv_r)
    );

    pll_srch_plidx u_hi_idx (.bound(hi_bd), .idx(hi_idx));
    pll_srch_plidx u_lo_idx (.bound(lo_bd), .idx(lo_idx));

    // Clamp a quotient into the legal divide-bound range 1..32.
    function automatic logic [5:0] clamp_bd(input logic [DIV_W-1:0] v);
        if (v == '0)                    clamp_bd = 6'd1;
        else if (v > DIV_W'(BND_MAX))   clamp_bd = 6'(BND_MAX);
        else                            clamp_bd = v[5:0];
    endfunction

    // Operand arithmetic shared by the search states.
    always_comb begin
        tt_x    = DIV_W'(tt);
        ref_x   = DIV_W'(ref_q);
        pad_nx  = tt_x + dv_q;
        maxv_nx = (pad_nx > DIV_W'(VCO_MAX)) ? pad_nx : DIV_W'(VCO_MAX);
        rat     = pl_ratio(pl);
        rat_x   = DIV_W'(rat);
        tv_c    = tt_x * rat_x;
        dlt     = (dv_q >= tt_x) ? (dv_q - tt_x) : (tt_x - dv_q);
        brat_x  = DIV_W'(pl_ratio(bp));
    end

    assign busy = (st != S_IDLE) && (st != S_DONE);

    // Search sequencer: bounds, PL/M/N loops, scoring and result load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            dv_go   <= 1'b0;
            dv_a    <= '0;
            dv_b    <= '0;
            done    <= 1'b0;
            m_o     <= '0;
            n_o     <= '0;
            pl_o    <= '0;
            err_o   <= '0;
            exact_o <= 1'b0;
            none_o  <= 1'b0;
            fout_o  <= '0;
        end else begin
            dv_go <= 1'b0;
            done  <= 1'b0;
            case (st)
                S_IDLE: if (start) begin
                    tt    <= {tgt_mhz, 1'b0};
                    ref_q <= ref_mhz;
                    bm    <= 8'(M_MAX);
                    bn    <= 8'(N_MIN);
                    bp    <= 4'(DEF_PL);
                    best  <= '1;
                    found <= 1'b0;
                    dv_go <= 1'b1;
                    dv_a  <= DIV_W'({tgt_mhz, 1'b0});
                    dv_b  <= DIV_W'(PAD_DIV);
                    st    <= S_PAD;
                end
                S_PAD: if (dv_done) begin
                    pad   <= pad_nx;
                    maxv  <= maxv_nx;
                    dv_go <= 1'b1;
                    dv_a  <= maxv_nx + pad_nx - DIV_W'(1);
                    dv_b  <= pad_nx;
                    st    <= S_HIB;
                end
                S_HIB: if (dv_done) begin
                    hi_bd <= clamp_bd(dv_q);
                    dv_go <= 1'b1;
                    dv_a  <= DIV_W'(VCO_MIN);
                    dv_b  <= pad;
                    st    <= S_LOB;
                end
                S_LOB: if (dv_done) begin
                    lo_bd <= clamp_bd(dv_q);
                    st    <= S_PLINIT;
                end
                S_PLINIT: begin
                    pl <= lo_idx;
                    st <= S_PLSET;
                end
                S_PLSET: begin
                    if (pl > hi_idx) st <= S_FIN;
                    else begin
                        m     <= 8'd1;
                        dv_go <= 1'b1;
                        dv_a  <= ref_x;
                        dv_b  <= DIV_W'(1);
                        st    <= S_UCHK;
                    end
                end
                S_UCHK: if (dv_done) begin
                    if (dv_q < DIV_W'(U_MIN))      st <= S_NEXTPL;
                    else if (dv_q > DIV_W'(U_MAX)) st <= S_NEXTM;
                    else begin
                        dv_go <= 1'b1;
                        dv_a  <= tv_c * DIV_W'(m);
                        dv_b  <= ref_x;
                        st    <= S_NDIV;
                    end
                end
                S_NDIV: if (dv_done) begin
                    if (dv_q > DIV_W'(N_MAX)) st <= S_NEXTPL;
                    else begin
                        n  <= dv_q[8:0];
                        n1 <= dv_q[8:0] + 9'(dv_r != '0);
                        st <= S_NCHK;
                    end
                end
                S_NCHK: begin
                    if (n > n1 || n > 9'(N_MAX)) st <= S_NEXTM;
                    else if (n < 9'(N_MIN))      n <= n + 9'd1;
                    else begin
                        dv_go <= 1'b1;
                        dv_a  <= ref_x * DIV_W'(n);
                        dv_b  <= DIV_W'(m);
                        st    <= S_VCO;
                    end
                end
                S_VCO: if (dv_done) begin
                    if (dv_q >= DIV_W'(VCO_MIN) && dv_q <= maxv) begin
                        dv_go <= 1'b1;
                        dv_a  <= dv_q + DIV_W'(rat >> 1);
                        dv_b  <= rat_x;
                        st    <= S_RND;
                    end else begin
                        n  <= n + 9'd1;
                        st <= S_NCHK;
                    end
                end
                S_RND: if (dv_done) begin
                    if (dlt < best) begin
                        best  <= dlt;
                        found <= 1'b1;
                        bm    <= m;
                        bn    <= n[7:0];
                        bp    <= pl;
                    end
                    if (dlt == '0) st <= S_FIN;
                    else begin
                        n  <= n + 9'd1;
                        st <= S_NCHK;
                    end
                end
                S_NEXTM: begin
                    if (m == 8'(M_MAX)) st <= S_NEXTPL;
                    else begin
                        m     <= m + 8'd1;
                        dv_go <= 1'b1;
                        dv_a  <= ref_x;
                        dv_b  <= DIV_W'(m) + DIV_W'(1);
                        st    <= S_UCHK;
                    end
                end
                S_NEXTPL: begin
                    pl <= pl + 4'd1;
                    st <= S_PLSET;
                end
                S_FIN: begin
                    dv_go <= 1'b1;
                    dv_a  <= ref_x * DIV_W'(bn);
                    dv_b  <= DIV_W'(bm) * brat_x;
                    st    <= S_FOUT;
                end
                S_FOUT: if (dv_done) begin
                    m_o     <= bm;
                    n_o     <= bn;
                    pl_o    <= bp;
                    err_o   <= found ? best[ERR_W-1:0] : '1;
                    exact_o <= found && (best == '0);
                    none_o  <= !found;
                    fout_o  <= FO_W'(dv_q >> 1);
                    done    <= 1'b1;
                    st      <= S_DONE;
                end
                S_DONE:  st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pll_srch_chk.sv
// Protocol and result-consistency properties for pll_coef_search,
// attached by bind. Assumes synchronous active-low reset.
module pll_srch_chk #(
    parameter int TGT_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [7:0]       m_o,
    input logic [7:0]       n_o,
    input logic [3:0]       pl_o,
    input logic [TGT_W+1:0] err_o,
    input logic             exact_o,
    input logic             none_o,
    input logic [TGT_W:0]   fout_o
);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R9
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done) |=> busy);
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable({m_o, n_o, pl_o, err_o, exact_o, none_o, fout_o}));
    // R7
    none_dflt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && none_o) |-> (m_o == 8'd255 && n_o == 8'd8 && pl_o == 4'd1 && !exact_o));
    // R2
    legal_rng_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !none_o) |-> (m_o != 8'd0 && n_o >= 8'd8 && pl_o <= 4'd14));
    // R6
    exact_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && exact_o) |-> (err_o == '0));
endmodule

bind pll_coef_search pll_srch_chk #(.TGT_W(TGT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .m_o(m_o), .n_o(n_o), .pl_o(pl_o), .err_o(err_o), .exact_o(exact_o),
    .none_o(none_o), .fout_o(fout_o)
);

// File: tb/tb_pll_coef_search.sv
`timescale 1ns/1ps
module tb_pll_coef_search;
    localparam int TGT_W = 11;
    localparam int REF_W = 8;
    localparam int NV    = 5;

    // Hand-derived vectors: target, reference, M, N, PL, err, exact, none, fout
    localparam int V_T[NV]  = '{72, 100, 1100, 50, 200};
    localparam int V_R[NV]  = '{12, 38, 12, 27, 10};
    localparam int V_M[NV]  = '{1, 3, 1, 2, 255};
    localparam int V_N[NV]  = '{96, 79, 183, 89, 8};
    localparam int V_P[NV]  = '{6, 4, 0, 8, 1};
    localparam int V_E[NV]  = '{0, 0, 4, 0, 8191};
    localparam int V_X[NV]  = '{1, 1, 0, 1, 0};
    localparam int V_NO[NV] = '{0, 0, 0, 0, 1};
    localparam int V_F[NV]  = '{72, 100, 1098, 50, 0};
    localparam int PST[15]  = '{72, 108, 180, 252, 324, 396, 468, 540, 612,
                                648, 684, 708, 756, 804, 852};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [TGT_W-1:0] tgt_mhz = '0;
    logic [REF_W-1:0] ref_mhz = '0;
    logic             busy, done, exact_o, none_o;
    logic [7:0]       m_o, n_o;
    logic [3:0]       pl_o;
    logic [TGT_W+1:0] err_o;
    logic [TGT_W:0]   fout_o;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    pll_coef_search #(.TGT_W(TGT_W), .REF_W(REF_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .tgt_mhz(tgt_mhz),
        .ref_mhz(ref_mhz), .busy(busy), .done(done), .m_o(m_o), .n_o(n_o),
        .pl_o(pl_o), .err_o(err_o), .exact_o(exact_o), .none_o(none_o),
        .fout_o(fout_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            nfail = nfail + 1;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    function automatic int ratio(input int i);
        case (i)
            0: return 1;   1: return 2;   2: return 3;   3: return 4;
            4: return 5;   5: return 6;   6: return 8;   7: return 10;
            8: return 12;  9: return 16;  10: return 12; 11: return 16;
            12: return 20; 13: return 24; default: return 32;
        endcase
    endfunction

    // Behavioural reference of the requirements (R3..R8)
    function automatic void model(input int t, input int rf, output int om,
                                  output int on, output int op, output int oe,
                                  output int ox, output int ono, output int ofo);
        int tt, pad, mx, hb, lb, lo, hi, bm, bn, bp, bd, d, tv, u, n0, n1, vco, lwv, dl;
        bit stop, got;
        tt = 2 * t; pad = tt + tt / 50; mx = (pad > 2064) ? pad : 2064;
        hb = (mx + pad - 1) / pad; hb = (hb < 1) ? 1 : ((hb > 32) ? 32 : hb);
        lb = 1000 / pad;           lb = (lb < 1) ? 1 : ((lb > 32) ? 32 : lb);
        lo = 14; hi = 14;
        for (int i = 14; i >= 0; i--) begin
            if (ratio(i) >= lb) lo = i;
            if (ratio(i) >= hb) hi = i;
        end
        bm = 255; bn = 8; bp = 1; bd = 0; got = 0; stop = 0;
        for (int p = lo; p <= hi && !stop; p++) begin
            d = ratio(p); tv = tt * d;
            for (int m = 1; m <= 255 && !stop; m++) begin
                u = rf / m;
                if (u < 12) break;
                if (u > 38) continue;
                n0 = tv * m / rf; n1 = (tv * m + rf - 1) / rf;
                if (n0 > 255) break;
                for (int n = n0; n <= n1 && !stop; n++) begin
                    if (n < 8) continue;
                    if (n > 255) break;
                    vco = rf * n / m;
                    if (vco >= 1000 && vco <= mx) begin
                        lwv = (vco + d / 2) / d;
                        dl = (lwv > tt) ? lwv - tt : tt - lwv;
                        if (!got || dl < bd) begin
                            got = 1; bd = dl; bm = m; bn = n; bp = p;
                            if (dl == 0) stop = 1;
                        end
                    end
                end
            end
        end
        om = bm; on = bn; op = bp; oe = got ? bd : 8191;
        ox = (got && bd == 0) ? 1 : 0; ono = got ? 0 : 1;
        ofo = (rf * bn / (bm * ratio(bp))) / 2;
    endfunction

    task automatic chk(input int act, input int exp, input string req, input string what);
        nchk = nchk + 1;
        if (act != exp) begin
            nfail = nfail + 1;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run(input int t, input int r);
        @(negedge clk);
        tgt_mhz = TGT_W'(t); ref_mhz = REF_W'(r); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(int'(busy), 1, "R9", "busy after start");
        while (!done) @(negedge clk);
    endtask

    task automatic cmp_all(input string req, input int em, input int en, input int ep,
                           input int ee, input int ex, input int eno, input int ef);
        chk(int'(m_o), em, req, "M");
        chk(int'(n_o), en, req, "N");
        chk(int'(pl_o), ep, req, "PL index (R1)");
        chk(int'(err_o), ee, req, "error (R6)");
        chk(int'(exact_o), ex, req, "exact (R5)");
        chk(int'(none_o), eno, req, "no-solution (R7)");
        chk(int'(fout_o), ef, req, "achieved freq (R8)");
    endtask

    // R2 legality of a returned solution
    task automatic chk_legal(input int t, input int r);
        int pad, mx, vco, u;
        pad = 2 * t + (2 * t) / 50; mx = (pad > 2064) ? pad : 2064;
        u = r / int'(m_o); vco = r * int'(n_o) / int'(m_o);
        chk(int'(u >= 12 && u <= 38), 1, "R2", "comparison freq in range");
        chk(int'(vco >= 1000 && vco <= mx), 1, "R2", "VCO in range");
        chk(int'(n_o >= 8), 1, "R2", "N lower limit");
    endtask

    initial begin
        int em, en, ep, ee, ex, eno, ef;
        // R10 reset state
        repeat (4) @(negedge clk);
        chk(int'(busy), 0, "R10", "busy in reset");
        chk(int'(done), 0, "R10", "done in reset");
        chk(int'({m_o, n_o, pl_o, err_o, exact_o, none_o, fout_o} == '0), 1, "R10", "outputs zero");
        rst_n = 1'b1;

        // Vector table: R1, R3 (raised ceiling, entry 2), R4, R5, R6, R7 (entry 4), R8
        for (int v = 0; v < NV; v++) begin
            run(V_T[v], V_R[v]);
            cmp_all("R5", V_M[v], V_N[v], V_P[v], V_E[v], V_X[v], V_NO[v], V_F[v]);
            if (V_NO[v] == 0) chk_legal(V_T[v], V_R[v]);
            @(negedge clk);
            chk(int'(done), 0, "R9", "done is one cycle");
        end

        // Model sweep over common targets: R3 R4 R5 R6 R8
        for (int r = 0; r < 2; r++) begin
            for (int k = 0; k < 15; k++) begin
                run(PST[k], (r == 0) ? 12 : 26);
                model(PST[k], (r == 0) ? 12 : 26, em, en, ep, ee, ex, eno, ef);
                cmp_all("R4", em, en, ep, ee, ex, eno, ef);
                if (eno == 0) chk_legal(PST[k], (r == 0) ? 12 : 26);
            end
        end

        // R9: start during a search is ignored
        @(negedge clk);
        tgt_mhz = 11'd100; ref_mhz = 8'd38; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        tgt_mhz = 11'd72; ref_mhz = 8'd12; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        cmp_all("R9", 3, 79, 4, 0, 1, 0, 100);

        // R9: results held while idle with changing inputs
        tgt_mhz = 11'd500; ref_mhz = 8'd20;
        repeat (50) @(negedge clk);
        chk(int'(busy), 0, "R9", "idle without start");
        cmp_all("R9", 3, 79, 4, 0, 1, 0, 100);

        // R10: reset during a search returns to idle
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(int'(busy), 0, "R10", "busy after mid-search reset");
        chk(int'(m_o), 0, "R10", "M after mid-search reset");
        rst_n = 1'b1;
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule